// File: doc/BRIEF.md
# Temperature-Compensated Refresh Scheduler

This block paces the refresh requests that a DRAM command arbiter must honour. A free-running down-counter marks the end of each refresh interval. The interval length comes from a clock-period parameter and from a two-bit case-temperature band that is driven at run time. Every band above the coolest one halves the refresh window of the band below it. Eight thousand one hundred and ninety-two refreshes must fit into each window. The window is 64 ms up to 85 °C, 32 ms up to 105 °C, 16 ms up to 115 °C and 8 ms up to 125 °C.

Each interval expiry adds one refresh to a debt ledger, and each arbiter acknowledge retires one. The request line stays high for as long as anything is owed. A busy arbiter can therefore postpone up to eight refreshes without losing any. An urgent flag tells the arbiter when the backlog is close to full, so that it can put refresh ahead of reads and writes. A sticky error flag records a refresh that was really lost.

A move to a hotter band shortens the running interval at once. A move to a cooler band lets the running interval finish at its current length, and the new length is used from the next reload onward.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `ref_req`, `ref_urgent` and `debt_overflow` are low and the debt is zero.
- R2: After reset is released with a fixed band, the first request appears exactly one interval of that band later: it is low after clock edge I-1 and high after edge I, counting edges from the release.
- R3: Band code 0 selects interval I0 = WINDOW_NS*1000/(REFS_PER_WINDOW*CLK_PERIOD_PS) cycles. Codes 1, 2 and 3 select I0/2, I0/4 and I0/8 cycles.
- R4: With a constant band and prompt acknowledges, expiries repeat exactly every I cycles. The acknowledge timing never shifts the expiry cadence.
- R5: `ref_req` is high exactly while the debt is nonzero. Each cycle with `ref_ack` high and nonzero debt retires one refresh. An acknowledge while the debt is zero has no effect.
- R6: When the band changes to a hotter one and the running count is longer than the new interval, the next expiry comes exactly Inew clock edges after the last edge that saw the old band.
- R7: When the band changes to a cooler one, the running interval ends at its old length. The expiry reload uses the band present on the expiry edge.
- R8: The debt saturates at DEBT_MAX (8). After 8 unacknowledged expiries, exactly 8 acknowledges are needed to drop the request.
- R9: `ref_urgent` is high exactly while the debt is at least URGENT_AT (7).
- R10: `debt_overflow` rises when an expiry occurs at a debt of DEBT_MAX with no acknowledge in that cycle. It then stays high until reset.
- R11: An expiry and an acknowledge in the same cycle leave the debt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| temp_band | input | 2 | Case-temperature band: 0 coolest, 3 hottest |
| ref_ack | input | 1 | Arbiter has issued one refresh |
| ref_req | output | 1 | One or more refreshes are owed |
| ref_urgent | output | 1 | Backlog has reached the urgent threshold |
| debt_overflow | output | 1 | Sticky: a refresh was lost to a full backlog |

## Verification
The hardest state to reach is the lost refresh. It needs nine interval expiries with no acknowledge at all, and the ninth one must land on a full ledger with no acknowledge in the same cycle. The bench holds the acknowledge low through the long coolest-band interval and counts clock edges from reset release. It samples the urgent flag around the edge of the seventh expiry and the overflow flag around the edge of the ninth. It then drains the ledger with single acknowledges and counts them, which shows that the debt stopped at eight. Band changes are placed on a known edge, so that the clamped and the unstretched expiries can be predicted to the cycle.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

   typedef enum logic [1:0] {
      BAND_COOL    = 2'd0,
      BAND_WARM    = 2'd1,
      BAND_HOT     = 2'd2,
      BAND_EXTREME = 2'd3
   } temp_band_e;

   localparam int NUM_BANDS = 4;

   // Cycles per refresh in the coolest band.
   function automatic longint base_interval(input longint window_ns,
                                            input longint refs,
                                            input longint clk_ps);
      return (window_ns * 64'd1000) / (refs * clk_ps);
   endfunction

endpackage

// File: rtl/rfsh_band_table.sv
module rfsh_band_table #(
   parameter int     CNT_W    = 11,
   parameter longint BASE_CYC = 1953
) (
   input  logic [1:0]       band_i,
   output logic [CNT_W-1:0] reload_o
);
   import rfsh_pkg::*;

   logic [CNT_W-1:0] tbl [NUM_BANDS];

   for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
      localparam longint CYC = BASE_CYC >> b;
      if (CYC < 2) begin : g_bad
         $error("band interval below two cycles");
      end
      assign tbl[b] = CNT_W'(CYC);
   end

   assign reload_o = tbl[band_i];

endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
   parameter int     CNT_W    = 11,
   parameter longint INIT_CYC = 1953
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] reload_i,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] INIT_VAL = CNT_W'(INIT_CYC - 1);

   logic [CNT_W-1:0] cnt_q, cnt_d, limit;

   assign limit    = reload_i - 1'b1;
   assign expire_o = (cnt_q == '0);

   always_comb begin
      if (cnt_q == '0)
         cnt_d = limit;
      else if (cnt_q > limit)
         cnt_d = limit - 1'b1;   // hotter band: clamp now
      else
         cnt_d = cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= INIT_VAL;
      else        cnt_q <= cnt_d;
   end

endmodule

// File: rtl/rfsh_debt_ledger.sv
module rfsh_debt_ledger #(
   parameter int DEBT_MAX  = 8,
   parameter int URGENT_AT = 7,
   parameter int DEBT_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              expire_i,
   input  logic              ack_i,
   output logic              req_o,
   output logic              urgent_o,
   output logic              ovf_o,
   output logic [DEBT_W-1:0] debt_o
);
   localparam logic [DEBT_W-1:0] FULL = DEBT_W'(DEBT_MAX);
   localparam logic [DEBT_W-1:0] URG  = DEBT_W'(URGENT_AT);

   logic [DEBT_W-1:0] debt_q;
   logic              ovf_q;
   logic              take;

   assign take = ack_i && (debt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         debt_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         unique case ({expire_i, take})
            2'b10: begin
               if (debt_q == FULL) ovf_q  <= 1'b1;
               else                debt_q <= debt_q + 1'b1;
            end
            2'b01:   debt_q <= debt_q - 1'b1;
            default: debt_q <= debt_q;
         endcase
      end
   end

   assign req_o    = (debt_q != '0);
   assign urgent_o = (debt_q >= URG);
   assign ovf_o    = ovf_q;
   assign debt_o   = debt_q;

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
   parameter int CLK_PERIOD_PS   = 4000,
   parameter int WINDOW_NS       = 64_000_000,
   parameter int REFS_PER_WINDOW = 8192,
   parameter int DEBT_MAX        = 8,
   parameter int URGENT_AT       = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] temp_band,
   input  logic       ref_ack,
   output logic       ref_req,
   output logic       ref_urgent,
   output logic       debt_overflow
);
   localparam longint BASE_CYC = rfsh_pkg::base_interval(WINDOW_NS, REFS_PER_WINDOW,
                                                         CLK_PERIOD_PS);
   localparam int     CNT_W    = $clog2(BASE_CYC + 1);
   localparam int     DEBT_W   = $clog2(DEBT_MAX + 1);

   if (CLK_PERIOD_PS <= 0 || REFS_PER_WINDOW <= 0) begin : g_chk_clk
      $error("clock period and refresh count must be positive");
   end
   if (DEBT_MAX < 1 || URGENT_AT < 1 || URGENT_AT > DEBT_MAX) begin : g_chk_debt
      $error("urgent threshold must lie within the debt range");
   end

   logic [CNT_W-1:0]  reload;
   logic              expire;
   logic [DEBT_W-1:0] debt_lvl;

   rfsh_band_table #(.CNT_W(CNT_W), .BASE_CYC(BASE_CYC)) u_table (
      .band_i   (temp_band),
      .reload_o (reload)
   );

   rfsh_interval_timer #(.CNT_W(CNT_W), .INIT_CYC(BASE_CYC)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload_i (reload),
      .expire_o (expire)
   );

   rfsh_debt_ledger #(.DEBT_MAX(DEBT_MAX), .URGENT_AT(URGENT_AT), .DEBT_W(DEBT_W)) u_ledger (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire_i (expire),
      .ack_i    (ref_ack),
      .req_o    (ref_req),
      .urgent_o (ref_urgent),
      .ovf_o    (debt_overflow),
      .debt_o   (debt_lvl)
   );

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
   parameter int DEBT_MAX = 8,
   parameter int DEBT_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_ack,
   input logic              ref_req,
   input logic              ref_urgent,
   input logic              debt_overflow,
   input logic              expire,
   input logic [DEBT_W-1:0] debt_lvl
);
   assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && !ref_ack) |=> ref_req);

   assert_req_drop_by_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ref_req) |-> $past(ref_ack));

   assert_urgent_has_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ref_urgent |-> ref_req);

   assert_debt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      debt_lvl <= DEBT_W'(DEBT_MAX));

   assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      debt_overflow |=> debt_overflow);

   assert_ovf_needs_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(debt_overflow) |-> ($past(debt_lvl) == DEBT_W'(DEBT_MAX) && $past(expire)));

   assert_expire_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);
endmodule

bind rfsh_sched rfsh_sched_chk #(.DEBT_MAX(DEBT_MAX), .DEBT_W(DEBT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ref_ack       (ref_ack),
   .ref_req       (ref_req),
   .ref_urgent    (ref_urgent),
   .debt_overflow (debt_overflow),
   .expire        (expire),
   .debt_lvl      (debt_lvl)
);

// File: tb/tb_rfsh_sched.sv
`timescale 1ns/1ps
module tb_rfsh_sched;
   // 2097152 ns window / 8192 refreshes / 4 ns gives 64 cycles in band 0
   localparam int I0 = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] temp_band = 2'd0;
   logic       ref_ack = 1'b0;
   logic       ref_req, ref_urgent, debt_overflow;
   int         n_chk = 0;
   int         n_err = 0;

   always #2 clk = ~clk;

   rfsh_sched #(.CLK_PERIOD_PS(4000), .WINDOW_NS(2097152), .REFS_PER_WINDOW(8192),
                .DEBT_MAX(8), .URGENT_AT(7)) dut (
      .clk(clk), .rst_n(rst_n), .temp_band(temp_band), .ref_ack(ref_ack),
      .ref_req(ref_req), .ref_urgent(ref_urgent), .debt_overflow(debt_overflow));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic ack_one();
      ref_ack = 1'b1;
      step(1);
      ref_ack = 1'b0;
   endtask

   // Leaves time at the negedge of reset release (edge 0).
   task automatic do_reset(input logic [1:0] band);
      @(negedge clk);
      rst_n = 1'b0; ref_ack = 1'b0; temp_band = band;
      step(2);
      check("R1 req in reset", ref_req, 0);
      check("R1 urgent in reset", ref_urgent, 0);
      check("R1 ovf in reset", debt_overflow, 0);
      rst_n = 1'b1;
      step(1);
      check("R1 req after release", ref_req, 0);
      @(negedge clk);
      rst_n = 1'b0;
      step(1);
      rst_n = 1'b1;
   endtask

   task automatic t_first_req_all_bands();
      for (int b = 0; b < 4; b++) begin
         int iv;
         iv = I0 >> b;
         do_reset(2'(b));
         step(iv - 1);
         check($sformatf("R2 R3 band%0d before first", b), ref_req, 0);
         step(1);
         check($sformatf("R2 R3 band%0d first req", b), ref_req, 1);
      end
   endtask

   task automatic t_cadence();
      do_reset(2'd1);
      step(32);
      check("R4 first", ref_req, 1);
      for (int k = 0; k < 2; k++) begin
         ack_one();
         check("R5 ack clears", ref_req, 0);
         step(30);
         check("R4 before next", ref_req, 0);
         step(1);
         check("R4 next expiry", ref_req, 1);
      end
      ack_one();
   endtask

   task automatic t_idle_ack();
      do_reset(2'd0);
      step(5);
      ack_one(); ack_one();
      step(I0 - 8);
      check("R5 idle ack no effect early", ref_req, 0);
      step(1);
      check("R5 idle ack req rises", ref_req, 1);
      ack_one();
      check("R5 single ack retires", ref_req, 0);
   endtask

   task automatic t_hotter();
      do_reset(2'd0);
      step(10);
      temp_band = 2'd3;
      step(7);
      check("R6 before clamped expiry", ref_req, 0);
      step(1);
      check("R6 clamped expiry", ref_req, 1);
      ack_one();
   endtask

   task automatic t_cooler();
      do_reset(2'd3);
      step(2);
      temp_band = 2'd0;
      step(5);
      check("R7 before old expiry", ref_req, 0);
      step(1);
      check("R7 old interval kept", ref_req, 1);
      ack_one();
      step(62);
      check("R7 new interval pending", ref_req, 0);
      step(1);
      check("R7 new interval applied", ref_req, 1);
      ack_one();
   endtask

   task automatic t_same_cycle();
      do_reset(2'd0);
      step(I0);
      check("R11 debt one", ref_req, 1);
      step(I0 - 1);
      ref_ack = 1'b1;
      step(1);
      ref_ack = 1'b0;
      check("R11 req kept", ref_req, 1);
      ack_one();
      check("R11 debt was one", ref_req, 0);
   endtask

   task automatic t_backlog();
      int drained;
      do_reset(2'd0);
      step(7 * I0 - 1);
      check("R9 urgent below", ref_urgent, 0);
      step(1);
      check("R9 urgent at seven", ref_urgent, 1);
      step(2 * I0 - 1);
      check("R10 no ovf at eight", debt_overflow, 0);
      step(1);
      check("R10 ovf on lost refresh", debt_overflow, 1);
      drained = 0;
      while (ref_req && drained < 20) begin
         ack_one();
         drained++;
         if (drained == 1) check("R9 urgent at seven after one ack", ref_urgent, 1);
         if (drained == 2) check("R9 urgent drops at six", ref_urgent, 0);
      end
      check("R8 saturated backlog", drained, 8);
      check("R10 ovf sticky", debt_overflow, 1);
      @(negedge clk);
      rst_n = 1'b0;
      step(1);
      check("R1 ovf cleared by reset", debt_overflow, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      t_first_req_all_bands();
      t_cadence();
      t_idle_ack();
      t_hotter();
      t_cooler();
      t_same_cycle();
      t_backlog();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule